// File: doc/BRIEF.md
# Directory-Protocol Cache Line Controller

This block is the cache-side controller of one node in a directory-based coherence system. It holds a small direct-mapped cache with one data word, one tag and one coherence state per line. Each line is Invalid, Shared or Exclusive. The processor side issues single-word reads and writes and holds each request until `cpu_ready` is returned. Read hits on any valid line and write hits on an Exclusive line finish in the same cycle.

Misses are not snooped. The controller sends a read-miss or write-miss message to the home directory, then waits for the data reply. Only one miss is outstanding at a time. A victim line that holds a different Exclusive address is written back before the new miss is sent. A Shared victim is dropped without any message. The home directory can also send two commands. An invalidate drops a Shared copy. A fetch makes an Exclusive line write its data back and fall to Shared.

An address splits into an index (the low log2(LINES) bits) and a tag (the remaining bits). Outgoing messages come from a register and appear one cycle after the decision that produces them.

Top module: `dir_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` is 0, and `cpu_ready` is 0 while no request is presented.
- R2: A read whose line is Invalid, or whose line holds a different tag in Shared state, emits a read-miss message (`out_kind` 1) carrying the request address one cycle later. `cpu_ready` rises in the cycle `rep_valid` is high, with `cpu_rdata` equal to `rep_data`, and the line becomes Shared.
- R3: A write to an Invalid line emits a write-miss message (`out_kind` 2). On the reply the line becomes Exclusive and holds the written data; the reply data is discarded.
- R4: A read that matches the tag of a Shared or Exclusive line completes in the same cycle with the stored data. It sends no message and does not change the line state.
- R5: A write that matches the tag of an Exclusive line completes in the same cycle with no message and replaces the stored data.
- R6: A write that matches the tag of a Shared line emits a write miss. On the reply the line becomes Exclusive holding the new data.
- R7: A fetch (`dir_kind` 1) whose address matches an Exclusive line produces, one cycle later, a write-back message (`out_kind` 3) carrying that address and the line data. The line becomes Shared.
- R8: An invalidate (`dir_kind` 0) whose address matches a Shared line makes the line Invalid.
- R9: Any other directory command has no effect and sends no message. This covers a tag mismatch, an Invalid line, a fetch to a Shared line, and an invalidate to an Exclusive line.
- R10: A miss whose line is Exclusive with a different tag first emits a write-back of the old address and data, one cycle after the request. The miss message follows one cycle after that.
- R11: A miss whose line is Shared with a different tag sends no write-back; only the miss message is sent.
- R12: While a miss is outstanding, `cpu_ready` stays 0 and no message is sent until the reply arrives. `cpu_ready` is 1 in the reply cycle.
- R13: In any cycle with `dir_valid` high, the processor request is not serviced: `cpu_ready` is 0 and the request produces no message. Outside the miss wait, handling resumes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request present, held until ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address, low bits are the line index |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| dir_valid | input | 1 | Directory command present (one cycle) |
| dir_kind | input | 1 | 0 invalidate, 1 fetch |
| dir_addr | input | ADDR_W | Address the command refers to |
| rep_valid | input | 1 | Data reply for the outstanding miss |
| rep_data | input | DATA_W | Reply data |
| out_valid | output | 1 | Outgoing message present (one cycle) |
| out_kind | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| out_addr | output | ADDR_W | Message address |
| out_data | output | DATA_W | Write-back data |

## Verification
Hits are due at 0 cycles: `cpu_ready` is checked 1 ns after the inputs change, before any clock edge. Each message appears one edge after its cause: a victim write-back one edge after the request, and the miss one edge later. For each operation, the bench counts the edges until ready and compares that count with the latency it expects. The expected latency comes from its own model of the line states, plus any delay the bench adds before the reply and one more cycle when a directory command is presented alongside the request. Messages are sampled at the falling edge after the edge that registers them. Directory commands are checked at the falling edge one edge after they are presented.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        MK_NONE   = 2'd0,
        MK_RDMISS = 2'd1,
        MK_WRMISS = 2'd2,
        MK_WBACK  = 2'd3
    } msg_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_VICT = 2'd1,
        RS_WAIT = 2'd2
    } rstate_e;

    localparam logic DIR_INVAL = 1'b0;
    localparam logic DIR_FETCH = 1'b1;

    // Line state after a directory command; unmatched cases keep the state.
    function automatic lstate_e dir_next(input logic kind, input lstate_e cur);
        if (kind == DIR_FETCH && cur == LS_EXC) return LS_SHR;
        if (kind == DIR_INVAL && cur == LS_SHR) return LS_INV;
        return cur;
    endfunction

endpackage

// File: rtl/cc_lines.sv
module cc_lines
    import coh_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    localparam int IW    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     idx_a,
    output lstate_e           a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IW-1:0]     idx_b,
    output lstate_e           b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wa_en,
    input  logic [IW-1:0]     wa_idx,
    input  lstate_e           wa_st,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IW-1:0]     wb_idx,
    input  lstate_e           wb_st
);

    lstate_e           st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Port A (processor side) wins over port B (directory side).
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                st_q[i]   <= LS_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (wa_en && wa_idx == IW'(i)) begin
                st_q[i]   <= wa_st;
                tag_q[i]  <= wa_tag;
                data_q[i] <= wa_data;
            end else if (wb_en && wb_idx == IW'(i)) begin
                st_q[i]   <= wb_st;
            end
        end
    end

    assign a_st   = st_q[idx_a];
    assign a_tag  = tag_q[idx_a];
    assign a_data = data_q[idx_a];
    assign b_st   = st_q[idx_b];
    assign b_tag  = tag_q[idx_b];
    assign b_data = data_q[idx_b];

endmodule

// File: rtl/cc_dir_port.sv
module cc_dir_port
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              dir_valid,
    input  logic              dir_kind,
    input  logic [ADDR_W-1:0] dir_addr,
    input  lstate_e           line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output lstate_e           upd_st,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    logic match;

    always_comb begin
        match   = dir_valid && line_st != LS_INV && line_tag == dir_addr[ADDR_W-1:IDX_W];
        upd_st  = dir_next(dir_kind, line_st);
        upd_en  = match && upd_st != line_st;
        wb_en   = match && dir_kind == DIR_FETCH && line_st == LS_EXC;
        wb_addr = dir_addr;
        wb_data = line_data;
    end

endmodule

// File: rtl/cc_req_ctrl.sv
module cc_req_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dir_busy,
    input  logic              rep_valid,
    input  logic [DATA_W-1:0] rep_data,
    input  lstate_e           line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              wr_en,
    output lstate_e           wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              msg_en,
    output msg_e              msg_kind,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data,
    output logic              in_wait,
    output logic              in_vict
);

    rstate_e cur_q, nxt;
    logic [TAG_W-1:0] ctag;
    logic tag_eq, rd_hit, wr_hit, dirty_victim;
    msg_e miss_kind;

    always_comb begin
        ctag         = cpu_addr[ADDR_W-1:IDX_W];
        tag_eq       = line_tag == ctag;
        rd_hit       = line_st != LS_INV && tag_eq;
        wr_hit       = line_st == LS_EXC && tag_eq;
        dirty_victim = line_st == LS_EXC && !tag_eq;
        miss_kind    = cpu_we ? MK_WRMISS : MK_RDMISS;

        nxt       = cur_q;
        cpu_ready = 1'b0;
        cpu_rdata = line_data;
        wr_en     = 1'b0;
        wr_st     = LS_INV;
        wr_tag    = ctag;
        wr_data   = cpu_wdata;
        msg_en    = 1'b0;
        msg_kind  = MK_NONE;
        msg_addr  = cpu_addr;
        msg_data  = line_data;

        unique case (cur_q)
            RS_IDLE: if (cpu_req && !dir_busy) begin
                if (cpu_we ? wr_hit : rd_hit) begin
                    cpu_ready = 1'b1;
                    if (cpu_we) begin
                        wr_en = 1'b1;
                        wr_st = LS_EXC;
                    end
                end else if (dirty_victim) begin
                    msg_en   = 1'b1;
                    msg_kind = MK_WBACK;
                    msg_addr = {line_tag, cpu_addr[IDX_W-1:0]};
                    wr_en    = 1'b1;
                    wr_st    = LS_INV;
                    wr_tag   = line_tag;
                    wr_data  = line_data;
                    nxt      = RS_VICT;
                end else begin
                    msg_en   = 1'b1;
                    msg_kind = miss_kind;
                    nxt      = RS_WAIT;
                end
            end
            RS_VICT: if (!dir_busy) begin
                msg_en   = 1'b1;
                msg_kind = miss_kind;
                nxt      = RS_WAIT;
            end
            RS_WAIT: if (rep_valid) begin
                cpu_ready = 1'b1;
                cpu_rdata = rep_data;
                wr_en     = 1'b1;
                wr_st     = cpu_we ? LS_EXC : LS_SHR;
                wr_data   = cpu_we ? cpu_wdata : rep_data;
                nxt       = RS_IDLE;
            end
            default: nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RS_IDLE;
        else     cur_q <= nxt;
    end

    assign in_wait = cur_q == RS_WAIT;
    assign in_vict = cur_q == RS_VICT;

endmodule

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dir_valid,
    input  logic              dir_kind,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              rep_valid,
    input  logic [DATA_W-1:0] rep_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    lstate_e           a_st, b_st, wa_st, upd_st;
    logic [TAG_W-1:0]  a_tag, b_tag, wa_tag;
    logic [DATA_W-1:0] a_data, b_data, wa_data;
    logic              wa_en, upd_en;
    logic              msg_en, dwb_en;
    msg_e              msg_kind;
    logic [ADDR_W-1:0] msg_addr, dwb_addr;
    logic [DATA_W-1:0] msg_data, dwb_data;
    logic              fsm_wait, fsm_vict;

    cc_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk    (clk),
        .rst    (rst),
        .idx_a  (cpu_addr[IDX_W-1:0]),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .idx_b  (dir_addr[IDX_W-1:0]),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .wa_en  (wa_en),
        .wa_idx (cpu_addr[IDX_W-1:0]),
        .wa_st  (wa_st),
        .wa_tag (wa_tag),
        .wa_data(wa_data),
        .wb_en  (upd_en),
        .wb_idx (dir_addr[IDX_W-1:0]),
        .wb_st  (upd_st)
    );

    cc_dir_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dir (
        .dir_valid(dir_valid),
        .dir_kind (dir_kind),
        .dir_addr (dir_addr),
        .line_st  (b_st),
        .line_tag (b_tag),
        .line_data(b_data),
        .upd_en   (upd_en),
        .upd_st   (upd_st),
        .wb_en    (dwb_en),
        .wb_addr  (dwb_addr),
        .wb_data  (dwb_data)
    );

    cc_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .dir_busy (dir_valid),
        .rep_valid(rep_valid),
        .rep_data (rep_data),
        .line_st  (a_st),
        .line_tag (a_tag),
        .line_data(a_data),
        .wr_en    (wa_en),
        .wr_st    (wa_st),
        .wr_tag   (wa_tag),
        .wr_data  (wa_data),
        .msg_en   (msg_en),
        .msg_kind (msg_kind),
        .msg_addr (msg_addr),
        .msg_data (msg_data),
        .in_wait  (fsm_wait),
        .in_vict  (fsm_vict)
    );

    // Single outgoing message register; a directory fetch write-back has the slot first.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= MK_NONE;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (dwb_en) begin
            out_valid <= 1'b1;
            out_kind  <= MK_WBACK;
            out_addr  <= dwb_addr;
            out_data  <= dwb_data;
        end else if (msg_en) begin
            out_valid <= 1'b1;
            out_kind  <= msg_kind;
            out_addr  <= msg_addr;
            out_data  <= msg_data;
        end else begin
            out_valid <= 1'b0;
            out_kind  <= MK_NONE;
        end
    end

endmodule

// File: rtl/cc_ctrl_chk.sv
module cc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       dir_valid,
    input logic       rep_valid,
    input logic       cpu_ready,
    input logic       out_valid,
    input logic [1:0] out_kind,
    input logic       fsm_wait,
    input logic       fsm_vict
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_wait_silent_r12: assert property (@(posedge clk) disable iff (rst)
        (fsm_wait && !dir_valid) |=> !out_valid);

    p_miss_enters_wait_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 2'd3) |-> fsm_wait);

    p_reply_completes_r12: assert property (@(posedge clk) disable iff (rst)
        (fsm_wait && rep_valid) |-> cpu_ready);

    p_victim_then_miss_r10: assert property (@(posedge clk) disable iff (rst)
        (fsm_vict && !dir_valid) |=> (out_valid && out_kind != 2'd3 && out_kind != 2'd0));

    p_dir_first_r13: assert property (@(posedge clk) disable iff (rst)
        (dir_valid && !fsm_wait) |-> !cpu_ready);

endmodule

bind dir_cache_ctrl cc_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_valid(dir_valid),
    .rep_valid(rep_valid),
    .cpu_ready(cpu_ready),
    .out_valid(out_valid),
    .out_kind (out_kind),
    .fsm_wait (fsm_wait),
    .fsm_vict (fsm_vict)
);

// File: tb/tb_dir_cache_ctrl.sv
module tb_dir_cache_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       dir_valid = 1'b0, dir_kind = 1'b0;
    logic [7:0] dir_addr = '0;
    logic       rep_valid = 1'b0;
    logic [7:0] rep_data = '0;
    logic       out_valid;
    logic [1:0] out_kind;
    logic [7:0] out_addr, out_data;

    int checks = 0, errors = 0;
    logic [7:0] val [256];
    logic [7:0] mem [256];
    int         rs [4];
    logic [5:0] rt [4];

    always #4 clk = ~clk;

    dir_cache_ctrl dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_addr(dir_addr),
        .rep_valid(rep_valid), .rep_data(rep_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(input logic ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [7:0] a, input logic [7:0] wd,
                         input logic wdir, input int hold, output int lat);
        int ix, elat, cd, nwb, nms;
        logic [5:0] tg;
        logic hit, vict, pend, done;
        logic [7:0] got, vaddr;
        string lb;
        ix = int'(a[1:0]);
        tg = a[7:2];
        hit  = rs[ix] != 0 && rt[ix] == tg && (!we || rs[ix] == 2);
        vict = !hit && rs[ix] == 2 && rt[ix] != tg;
        vaddr = {rt[ix], a[1:0]};
        if (wdir) lb = "R13";
        else if (hit) lb = we ? "R5" : "R4";
        else if (vict) lb = "R10";
        else if (rs[ix] == 1 && rt[ix] != tg) lb = "R11";
        else if (we) lb = (rs[ix] == 1) ? "R6" : "R3";
        else lb = "R2";
        elat = hit ? 0 : ((vict ? 2 : 1) + hold);
        if (wdir) elat++;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (wdir) begin
            dir_valid = 1'b1; dir_kind = 1'b0;
            dir_addr = {rt[ix ^ 1] + 6'd1, 2'(ix ^ 1)};
        end
        lat = 0; pend = 0; done = 0; cd = 0; nwb = 0; nms = 0; got = '0;
        while (!done && lat < 20) begin
            #1;
            if (cpu_ready) begin
                done = 1'b1;
                got = cpu_rdata;
            end else begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                dir_valid = 1'b0;
                rep_valid = 1'b0;
                if (pend) begin
                    chk(!out_valid, "R12", int'(out_valid), 0);
                    if (cd == 0) begin
                        rep_valid = 1'b1; rep_data = mem[a]; pend = 1'b0;
                    end else cd--;
                end
                if (out_valid) begin
                    if (out_kind == 2'd3) begin
                        nwb++;
                        chk(out_addr == vaddr, "R10", int'(out_addr), int'(vaddr));
                        chk(out_data == val[vaddr], "R10", int'(out_data), int'(val[vaddr]));
                        mem[out_addr] = out_data;
                    end else begin
                        nms++;
                        chk(out_kind == (we ? 2'd2 : 2'd1), lb, int'(out_kind), we ? 2 : 1);
                        chk(out_addr == a, lb, int'(out_addr), int'(a));
                        if (hold == 0) begin
                            rep_valid = 1'b1; rep_data = mem[a];
                        end else begin
                            pend = 1'b1; cd = hold - 1;
                        end
                    end
                end
            end
        end
        chk(done, lb, int'(done), 1);
        chk(lat == elat, lb, lat, elat);
        if (!we) chk(got == val[a], lb, int'(got), int'(val[a]));
        chk(nwb == int'(vict), vict ? "R10" : "R11", nwb, int'(vict));
        chk(nms == int'(!hit), lb, nms, int'(!hit));
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; rep_valid = 1'b0;
        #1 chk(!out_valid, lb, int'(out_valid), 0);
        if (we) begin
            val[a] = wd; rs[ix] = 2;
        end else if (!hit) rs[ix] = 1;
        rt[ix] = tg;
    endtask

    task automatic do_dir(input logic kind, input logic [7:0] a);
        int ix;
        logic [5:0] tg;
        logic match, ewb;
        string lb;
        ix = int'(a[1:0]);
        tg = a[7:2];
        match = rs[ix] != 0 && rt[ix] == tg;
        ewb = match && kind && rs[ix] == 2;
        lb = ewb ? "R7" : ((match && !kind && rs[ix] == 1) ? "R8" : "R9");
        @(negedge clk);
        dir_valid = 1'b1; dir_kind = kind; dir_addr = a;
        @(posedge clk);
        @(negedge clk);
        dir_valid = 1'b0;
        #1;
        chk(out_valid == ewb, lb, int'(out_valid), int'(ewb));
        if (ewb && out_valid) begin
            chk(out_kind == 2'd3, "R7", int'(out_kind), 3);
            chk(out_addr == a, "R7", int'(out_addr), int'(a));
            chk(out_data == val[a], "R7", int'(out_data), int'(val[a]));
            mem[a] = out_data;
        end
        if (ewb) rs[ix] = 1;
        else if (match && !kind && rs[ix] == 1) rs[ix] = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] lf;
        for (int i = 0; i < 256; i++) begin
            val[i] = 8'(i * 3 + 1);
            mem[i] = 8'(i * 3 + 1);
        end
        for (int i = 0; i < 4; i++) begin
            rs[i] = 0; rt[i] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!cpu_ready, "R1", int'(cpu_ready), 0);
        chk(!out_valid, "R1", int'(out_valid), 0);
        for (int i = 0; i < 4; i++) begin
            do_op(1'b0, 8'(i + 4 * i), 8'h00, 1'b0, 0, lat);
            chk(lat == 1, "R1", lat, 1);
        end
        // directed walk through the line states of index 1
        do_op(1'b0, 8'h05, 8'h00, 1'b0, 0, lat);
        do_op(1'b1, 8'h05, 8'hA1, 1'b0, 0, lat);
        do_op(1'b1, 8'h05, 8'hA2, 1'b0, 0, lat);
        do_op(1'b0, 8'h05, 8'h00, 1'b0, 0, lat);
        do_dir(1'b0, 8'h05);
        do_dir(1'b1, 8'h09);
        do_dir(1'b1, 8'h05);
        do_op(1'b0, 8'h05, 8'h00, 1'b0, 0, lat);
        do_dir(1'b1, 8'h05);
        do_dir(1'b0, 8'h05);
        do_op(1'b0, 8'h05, 8'h00, 1'b0, 0, lat);
        do_op(1'b1, 8'h09, 8'hB3, 1'b0, 0, lat);
        do_op(1'b0, 8'h05, 8'h00, 1'b0, 0, lat);
        do_op(1'b1, 8'h22, 8'hC4, 1'b0, 0, lat);
        do_dir(1'b0, 8'h22);
        do_op(1'b0, 8'h2E, 8'h00, 1'b0, 3, lat);
        do_op(1'b1, 8'h0F, 8'hD5, 1'b1, 0, lat);
        do_op(1'b0, 8'h0F, 8'h00, 1'b1, 0, lat);
        // pseudo-random sweep over 4 tags x 4 indexes
        lf = 16'hACE1;
        for (int n = 0; n < 800; n++) begin
            logic [7:0] a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = {4'b0000, lf[4:3], lf[6:5]};
            case (lf[2:0])
                3'd0, 3'd1, 3'd2: do_op(1'b0, a, 8'h00, 1'b0, int'(lf[9:8]), lat);
                3'd3, 3'd4:       do_op(1'b1, a, lf[15:8], 1'b0, int'(lf[9:8]), lat);
                3'd5:             do_dir(1'b1, a);
                3'd6:             do_dir(1'b0, a);
                default:          do_op(lf[11], a, lf[15:8], 1'b1, 0, lat);
            endcase
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule